// File: doc/BRIEF.md
# Fetch Stall Stash Buffer

This block sits between an instruction cache and the decode stage. The cache RAM gets a full clock cycle for every read and takes its read address straight from the registered fetch address, so it cannot be held back combinationally. When decode raises its stall, the fetch address has already moved on and the RAM is already reading the next word. The word on the cache output in the stall cycle would then be lost. The buffer saves that word in a one-entry stash and hands it to decode, in place of the cache output, in the first cycle after the stall is released.

The upstream contract is as follows. The fetch address register freezes in every cycle in which `stall_i` is high, and it jumps to a new target in a cycle in which `flush_i` is high. The cache output register reloads on every edge from the address held during the previous cycle.

A cache word therefore counts as new only if the address advanced after it was read. That is the case when neither `stall_i` nor `flush_i` was high in the previous cycle. Any other word is a repeat or a stale read, and the block drops it. Decode accepts a word in a cycle with `dec_valid_o` high and `stall_i` low.

Top module: `fetch_stash_buf`

## Requirements
- R1: After reset the stash is empty and `dec_valid_o` stays low until a qualified cache word arrives.
- R2: With the stash empty, a qualified cache word appears on `dec_word_o`/`dec_addr_o` in the same cycle with `dec_valid_o` high.
- R3: A cache word presented in the cycle after a cycle with `stall_i` high is ignored: it is never shown to decode and never loaded into the stash.
- R4: A qualified cache word present in a cycle with `stall_i` high and an empty stash is loaded into the stash. From the next cycle on, decode sees that word with `dec_valid_o` high.
- R5: In the first cycle with `stall_i` low and a full stash, decode sees the stashed word instead of the cache output. The stash is empty in the following cycle.
- R6: While the stash is full and `stall_i` stays high, the stash contents do not change, whatever the cache presents.
- R7: `flush_i` empties the stash. `dec_valid_o` is low in the flush cycle. A cache word presented in the cycle after a flush is ignored.
- R8: Under any pattern of stalls, read bubbles and flushes, the addresses accepted by decode run in order from the reset address or from the latest flush target, stepping by one word, with no gaps and no repeats. Each address carries its own word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Redirect: discard the stash and the next cache word |
| stall_i | input | 1 | Stall from decode, also freezes the fetch address |
| cache_valid_i | input | 1 | Cache output word valid |
| cache_word_i | input | WORD_W | Cache output instruction word |
| cache_addr_i | input | ADDR_W | Address of the cache output word |
| dec_valid_o | output | 1 | Word to decode valid |
| dec_word_o | output | WORD_W | Instruction word to decode |
| dec_addr_o | output | ADDR_W | Address of the word to decode |

## Verification
The hardest case to reach from the ports is a stall that starts in exactly the cycle in which a committed cache word is on the input. If that stall then drops for one cycle and comes back, the stash drains and a fresh word must be captured. Flushes that land while the stash is full are equally hard to produce. The bench models the fetch address register and the cache output register as the contract describes, and toggles stall, read bubbles and flushes at random from a fixed seed, so these collisions occur many times. Directed sequences pin down the exact cycles of capture, the ignored repeat word, replay and flush.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  typedef enum logic {
    SRC_CACHE = 1'b0,
    SRC_STASH = 1'b1
  } out_src_e;
endpackage

// File: rtl/ssb_qualify.sv
// Marks a cache word as new only if the fetch address advanced after its read.
module ssb_qualify (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic stall_i,
  input  logic cache_valid_i,
  output logic in_ok_o
);
  logic hold_q;
  logic flush_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      hold_q  <= stall_i;
      flush_q <= flush_i;
    end
  end

  assign in_ok_o = cache_valid_i && !hold_q && !flush_q;

  a_r3_repeat_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> !in_ok_o);
  a_r7_stale_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !in_ok_o);
endmodule

// File: rtl/ssb_stash.sv
module ssb_stash #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              stall_i,
  input  logic              in_ok_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              full_o,
  output logic [WORD_W-1:0] word_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int EntryW = WORD_W + ADDR_W;

  logic              full_q;
  logic [EntryW-1:0] data_q;
  logic              load;
  logic              drain;

  assign load  = !full_q && stall_i && in_ok_i && !flush_i;
  assign drain = full_q && !stall_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
    end else if (flush_i || drain) begin
      full_q <= 1'b0;
    end else if (load) begin
      full_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_q <= '0;
    else if (load) data_q <= {word_i, addr_i};
  end

  assign full_o = full_q;
  assign word_o = data_q[EntryW-1:ADDR_W];
  assign addr_o = data_q[ADDR_W-1:0];

  a_r4_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_q && stall_i && in_ok_i && !flush_i)
      |=> (full_q && addr_o == $past(addr_i) && word_o == $past(word_i)));
  a_r6_hold_contents: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && stall_i && !flush_i) |=> (full_q && $stable(data_q)));
  a_r6_no_collision: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q |-> !in_ok_i);
  a_r5_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !stall_i) |=> !full_q);
  a_r7_flush_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !full_q);
endmodule

// File: rtl/ssb_out_mux.sv
module ssb_out_mux
  import ssb_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              flush_i,
  input  logic              in_ok_i,
  input  logic [WORD_W-1:0] cache_word_i,
  input  logic [ADDR_W-1:0] cache_addr_i,
  input  logic              stash_full_i,
  input  logic [WORD_W-1:0] stash_word_i,
  input  logic [ADDR_W-1:0] stash_addr_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] word_o,
  output logic [ADDR_W-1:0] addr_o
);
  out_src_e sel;

  always_comb begin
    sel     = stash_full_i ? SRC_STASH : SRC_CACHE;
    valid_o = !flush_i && (stash_full_i || in_ok_i);
    unique case (sel)
      SRC_STASH: begin
        word_o = stash_word_i;
        addr_o = stash_addr_i;
      end
      default: begin
        word_o = cache_word_i;
        addr_o = cache_addr_i;
      end
    endcase
  end
endmodule

// File: rtl/fetch_stash_buf.sv
module fetch_stash_buf #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              stall_i,
  input  logic              cache_valid_i,
  input  logic [WORD_W-1:0] cache_word_i,
  input  logic [ADDR_W-1:0] cache_addr_i,
  output logic              dec_valid_o,
  output logic [WORD_W-1:0] dec_word_o,
  output logic [ADDR_W-1:0] dec_addr_o
);
  logic              in_ok;
  logic              stash_full;
  logic [WORD_W-1:0] stash_word;
  logic [ADDR_W-1:0] stash_addr;

  ssb_qualify i_qualify (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .flush_i       (flush_i),
    .stall_i       (stall_i),
    .cache_valid_i (cache_valid_i),
    .in_ok_o       (in_ok)
  );

  ssb_stash #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) i_stash (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_i),
    .stall_i (stall_i),
    .in_ok_i (in_ok),
    .word_i  (cache_word_i),
    .addr_i  (cache_addr_i),
    .full_o  (stash_full),
    .word_o  (stash_word),
    .addr_o  (stash_addr)
  );

  ssb_out_mux #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) i_out_mux (
    .flush_i      (flush_i),
    .in_ok_i      (in_ok),
    .cache_word_i (cache_word_i),
    .cache_addr_i (cache_addr_i),
    .stash_full_i (stash_full),
    .stash_word_i (stash_word),
    .stash_addr_i (stash_addr),
    .valid_o      (dec_valid_o),
    .word_o       (dec_word_o),
    .addr_o       (dec_addr_o)
  );

  a_r7_quiet_on_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !dec_valid_o);
  a_r5_replay_stash: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && !flush_i && dec_valid_o) |=> (!flush_i -> (dec_valid_o && $stable(dec_addr_o))));
endmodule

// File: tb/test_fetch_stash_buf.sv
module test_fetch_stash_buf;
  localparam int WW = 32;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush = 1'b0;
  logic          stall = 1'b0;
  logic          cv;
  logic [WW-1:0] cw;
  logic [AW-1:0] ca;
  logic          dv;
  logic [WW-1:0] dw;
  logic [AW-1:0] da;

  int total = 0;
  int bad = 0;
  int accepted = 0;
  logic          mon_en = 1'b0;
  logic [AW-1:0] exp_addr = '0;
  logic          src_rd = 1'b1;
  logic [AW-1:0] src_a;
  logic [AW-1:0] flush_tgt = '0;

  always #5 clk = ~clk;

  function automatic logic [WW-1:0] word_of(logic [AW-1:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  // Fetch address register plus cache output register, per the upstream contract.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_a <= '0;
      cv    <= 1'b0;
      cw    <= '0;
      ca    <= '0;
    end else begin
      cv <= src_rd;
      ca <= src_a;
      cw <= word_of(src_a);
      if (flush) src_a <= flush_tgt;
      else if (!stall && src_rd) src_a <= src_a + 4;
    end
  end

  fetch_stash_buf #(.WORD_W(WW), .ADDR_W(AW)) i_fetch_stash_buf (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .flush_i       (flush),
    .stall_i       (stall),
    .cache_valid_i (cv),
    .cache_word_i  (cw),
    .cache_addr_i  (ca),
    .dec_valid_o   (dv),
    .dec_word_o    (dw),
    .dec_addr_o    (da)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R8 stream monitor: every accepted word is the next expected one.
  always @(negedge clk) begin
    if (mon_en && dv && !stall && !flush) begin
      check(da == exp_addr, "R8 order", da, exp_addr);
      check(dw == word_of(da), "R8 word", dw, word_of(da));
      exp_addr = exp_addr + 4;
      accepted++;
    end
  end

  task automatic cyc(input bit s, input bit f, input bit rd);
    @(posedge clk);
    #1;
    stall  = s;
    flush  = f;
    src_rd = rd;
    if (f) begin
      flush_tgt = flush_tgt + 32'h1000;
      exp_addr  = flush_tgt;
    end
  endtask

  task automatic directed_stall(input int len);
    logic [AW-1:0] x;
    repeat (3) cyc(0, 0, 1);
    cyc(1, 0, 1);
    x = exp_addr;
    @(negedge clk);
    check(dv && da == x, "R4 word in stall cycle", da, x);
    for (int i = 0; i < len; i++) begin
      cyc(1, 0, 1);
      @(negedge clk);
      check(dv && da == x && dw == word_of(x), "R4 R6 stash shown during stall", da, x);
      check(cv && ca == x + 4, "R3 repeat word on cache input", ca, x + 4);
    end
    cyc(0, 0, 1);
    @(negedge clk);
    check(dv && da == x, "R5 replay of stash", da, x);
    cyc(0, 0, 1);
    @(negedge clk);
    check(dv && da == x + 4, "R5 stash drained, cache resumes", da, x + 4);
  endtask

  task automatic directed_flush();
    logic [AW-1:0] t;
    repeat (2) cyc(0, 0, 1);
    cyc(1, 0, 1);
    cyc(1, 0, 1);
    cyc(0, 1, 1);
    t = exp_addr;
    @(negedge clk);
    check(!dv, "R7 quiet in flush cycle", {63'd0, dv}, 64'd0);
    cyc(0, 0, 1);
    @(negedge clk);
    check(!dv && cv, "R7 stale word after flush dropped", {62'd0, dv, cv}, 64'd1);
    cyc(0, 0, 1);
    @(negedge clk);
    check(dv && da == t, "R7 R8 flush target first", da, t);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    stall  = 1'b1;
    src_rd = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!dv, "R1 idle after reset", {63'd0, dv}, 64'd0);
    cyc(1, 0, 0);
    @(negedge clk);
    check(!dv, "R1 stash empty after reset", {63'd0, dv}, 64'd0);
    cyc(0, 0, 0);
    @(negedge clk);
    check(!dv, "R1 nothing before a cache word", {63'd0, dv}, 64'd0);
    mon_en = 1'b1;

    cyc(0, 0, 1);
    cyc(0, 0, 1);
    @(negedge clk);
    check(dv && cv && da == ca && dw == cw, "R2 pass-through", da, ca);

    directed_stall(1);
    directed_stall(4);
    directed_flush();

    // stall dropped for a single cycle, then back
    repeat (2) cyc(0, 0, 1);
    cyc(1, 0, 1);
    cyc(0, 0, 1);
    cyc(1, 0, 1);
    cyc(1, 0, 1);
    cyc(0, 0, 1);
    repeat (2) cyc(0, 0, 1);

    for (int i = 0; i < 6000; i++) begin
      cyc(($urandom % 100) < 35, ($urandom % 100) < 2, ($urandom % 100) < 85);
    end
    cyc(0, 0, 1);
    repeat (4) cyc(0, 0, 1);
    check(accepted > 1500, "R8 forward progress", accepted, 1500);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule